// File: doc/BRIEF.md
# Dual-mode leading-digit detector and magnitude comparator

This block finds the position of one target digit inside a 2^H-bit vector, or compares two H-wide… more exactly, two 2^(H-1)-bit operands whose bits are interleaved in that vector. One shared binary tree does both jobs. A mode input changes only the leaf cells: each leaf either looks for any set bit in its pair, or for a pair whose two bits differ. Two modifier inputs adjust the search. One complements every input bit, so the tree hunts for zeros instead of ones. The other reverses the weight order, so the tree reports the trailing digit instead of the leading one.

Each tree level is one stage. The stage ORs the existence flags of its two halves and picks the sub-position of the half that wins. A multiplexer controlled by the reverse input decides which half has priority. The tree itself is pure logic with H stages. The top module holds the existence flag and the position in registers that have a synchronous active-high reset. A result is therefore visible one clock after its inputs are presented.

Typical uses are normalisation shift counts, finding the first set bit or first clear bit from either end, and ordering two unsigned operands.

Top module: `cldd_top`

## Requirements
- R1: While `rst` is high at a rising edge, `found` and `pos` are cleared to 0 on that edge, whatever the data inputs carry.
- R2: `found` and `pos` change only at a rising edge. They reflect the inputs sampled at the previous rising edge, so the latency is one cycle.
- R3: With `cmp_mode`=0, `inv`=0 and `flip`=0, `found` is the OR of all bits of `vec_in`. `pos` is the index of the highest set bit, with bit 0 as the rightmost bit.
- R4: With `cmp_mode`=0, `inv`=1 and `flip`=0, every input bit is complemented first. `found` is 1 when any bit is 0, and `pos` is the index of the highest clear bit.
- R5: With `cmp_mode`=0, `inv`=0 and `flip`=1, `pos` is the index of the lowest set bit, and `found` is the OR of all bits.
- R6: With `cmp_mode`=0, `inv`=1 and `flip`=1, `pos` is the index of the lowest clear bit, and `found` is 1 when any bit is 0.
- R7: With `cmp_mode`=1, operand A bit i is taken from `vec_in[2i+1]` and operand B bit i from `vec_in[2i]`. `found` is 1 exactly when A differs from B. With `inv`=0 and `flip`=0 and A differing from B:
  - `pos[0]` is 1 exactly when A is greater than B.
  - `pos[H-1:1]` is the index of the highest bit where A and B differ.
- R8: With `cmp_mode`=1, `inv`=1, `flip`=0 and A differing from B:
  - `pos[0]` is 1 exactly when A is less than B.
  - `pos[H-1:1]` is the index of the highest differing bit.
- R9: With `cmp_mode`=1, `flip`=1 and A differing from B:
  - `pos[H-1:1]` is the index of the lowest differing bit.
  - `pos[0]` is A's bit at that index XOR `inv`.
- R10: In detector mode with no target digit present, `found` is 0. `pos` is all zeros when `flip`=0 and all ones when `flip`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output registers |
| rst | input | 1 | Synchronous reset, active high |
| vec_in | input | 2^H | Search vector, or interleaved operand pairs in comparator mode |
| cmp_mode | input | 1 | 1 selects the comparator, 0 selects the digit detector |
| inv | input | 1 | Complements every input bit before evaluation |
| flip | input | 1 | 1 searches for the trailing digit instead of the leading one |
| found | output | 1 | Registered existence flag |
| pos | output | H | Registered position of the found digit |

## Verification
Every result is due exactly one rising edge after its inputs are applied. The bench therefore changes inputs on a falling edge and compares `found` and `pos` on the next falling edge, after one capture edge has passed. One dedicated check looks between the drive and the capture edge and confirms that the previous result is still held (R2). Each run compares against positions found by a loop scan and against magnitude comparison of the de-interleaved operands. It sweeps all vectors for every mode, `inv` and `flip` combination of an 8-bit configuration.

// File: rtl/cldd_pkg.sv
package cldd_pkg;

  // Bit offset of level k inside the flat existence vector of a tree of depth h.
  function automatic int exist_off(input int h, input int k);
    int acc;
    acc = 0;
    for (int j = 1; j < k; j++) acc += (1 << h) >> j;
    return acc;
  endfunction

  // Bit offset of level k inside the flat position vector (level j nodes carry j bits).
  function automatic int posn_off(input int h, input int k);
    int acc;
    acc = 0;
    for (int j = 1; j < k; j++) acc += ((1 << h) >> j) * j;
    return acc;
  endfunction

endpackage

// File: rtl/cldd_leaf.sv
module cldd_leaf (
  input  logic bit_hi,
  input  logic bit_lo,
  input  logic cmp_mode,
  input  logic inv,
  input  logic flip,
  output logic exist,
  output logic posn
);
  logic a_t, b_t;

  assign a_t   = bit_hi ^ inv;
  assign b_t   = bit_lo ^ inv;
  // detector: any target in the pair; comparator: the pair differs
  assign exist = cmp_mode ? (a_t ^ b_t) : (a_t | b_t);
  // leading search favours the upper bit, trailing search favours the lower bit
  assign posn  = flip ? ~b_t : a_t;
endmodule

// File: rtl/cldd_merge.sv
module cldd_merge #(
  parameter int SW = 1
) (
  input  logic          e_hi,
  input  logic          e_lo,
  input  logic [SW-1:0] p_hi,
  input  logic [SW-1:0] p_lo,
  input  logic          flip,
  output logic          exist,
  output logic [SW:0]   posn
);
  assign exist = e_hi | e_lo;

  always_comb begin
    if (!flip) begin
      posn = {e_hi, (e_hi ? p_hi : p_lo)};
    end else begin
      posn = {~e_lo, (e_lo ? p_lo : p_hi)};
    end
  end
endmodule

// File: rtl/cldd_tree.sv
module cldd_tree
  import cldd_pkg::*;
#(
  parameter int H = 4
) (
  input  logic [(1<<H)-1:0] vec_in,
  input  logic              cmp_mode,
  input  logic              inv,
  input  logic              flip,
  output logic              found,
  output logic [H-1:0]      pos
);
  localparam int W      = 1 << H;
  localparam int E_BITS = exist_off(H, H + 1);
  localparam int P_BITS = posn_off(H, H + 1);

  logic [E_BITS-1:0] e_f;
  logic [P_BITS-1:0] p_f;

  for (genvar n = 0; n < W / 2; n++) begin : g_leaf
    cldd_leaf u_leaf (
      .bit_hi  (vec_in[2*n+1]),
      .bit_lo  (vec_in[2*n]),
      .cmp_mode(cmp_mode),
      .inv     (inv),
      .flip    (flip),
      .exist   (e_f[n]),
      .posn    (p_f[n])
    );
  end

  for (genvar k = 2; k <= H; k++) begin : g_lvl
    localparam int EI = exist_off(H, k - 1);
    localparam int PI = posn_off(H, k - 1);
    localparam int EO = exist_off(H, k);
    localparam int PO = posn_off(H, k);
    for (genvar n = 0; n < (W >> k); n++) begin : g_node
      cldd_merge #(.SW(k - 1)) u_merge (
        .e_hi (e_f[EI + 2*n + 1]),
        .e_lo (e_f[EI + 2*n]),
        .p_hi (p_f[PI + (2*n + 1)*(k - 1) +: (k - 1)]),
        .p_lo (p_f[PI + (2*n)*(k - 1) +: (k - 1)]),
        .flip (flip),
        .exist(e_f[EO + n]),
        .posn (p_f[PO + n*k +: k])
      );
    end
  end

  assign found = e_f[exist_off(H, H)];
  assign pos   = p_f[posn_off(H, H) +: H];
endmodule

// File: rtl/cldd_top.sv
module cldd_top #(
  parameter int H = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [(1<<H)-1:0] vec_in,
  input  logic              cmp_mode,
  input  logic              inv,
  input  logic              flip,
  output logic              found,
  output logic [H-1:0]      pos
);
  logic         found_c;
  logic [H-1:0] pos_c;

  cldd_tree #(.H(H)) u_tree (
    .vec_in  (vec_in),
    .cmp_mode(cmp_mode),
    .inv     (inv),
    .flip    (flip),
    .found   (found_c),
    .pos     (pos_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      found <= 1'b0;
      pos   <= '0;
    end else begin
      found <= found_c;
      pos   <= pos_c;
    end
  end
endmodule

// File: rtl/cldd_chk.sv
module cldd_chk #(
  parameter int H = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [(1<<H)-1:0] vec_in,
  input logic              cmp_mode,
  input logic              inv,
  input logic              flip,
  input logic              found,
  input logic [H-1:0]      pos
);
  localparam int W = 1 << H;
  localparam int HW = W / 2;

  logic [HW-1:0] op_a, op_b;
  always_comb begin
    for (int i = 0; i < HW; i++) begin
      op_a[i] = vec_in[2*i+1];
      op_b[i] = vec_in[2*i];
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!found && pos == '0));

  p_found_or_r3: assert property (@(posedge clk) disable iff (rst)
    (!cmp_mode && !inv) |=> (found == (|$past(vec_in))));

  p_lead_one_r3: assert property (@(posedge clk) disable iff (rst)
    (!cmp_mode && !inv && !flip) |=> (!found || (($past(vec_in) >> pos) == W'(1))));

  p_lead_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (!cmp_mode && inv && !flip) |=> (!found || ((~$past(vec_in) >> pos) == W'(1))));

  p_trail_one_r5: assert property (@(posedge clk) disable iff (rst)
    (!cmp_mode && !inv && flip) |=> (!found ||
      (((($past(vec_in) >> pos) & W'(1)) == W'(1)) &&
       (($past(vec_in) & ((W'(1) << pos) - W'(1))) == '0))));

  p_cmp_equal_r7: assert property (@(posedge clk) disable iff (rst)
    cmp_mode |=> (found == ($past(op_a) != $past(op_b))));

  p_cmp_greater_r7: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode && !inv && !flip) |=> (!found || (pos[0] == ($past(op_a) > $past(op_b)))));

  p_cmp_less_r8: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode && inv && !flip) |=> (!found || (pos[0] == ($past(op_a) < $past(op_b)))));
endmodule

bind cldd_top cldd_chk #(.H(H)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .vec_in  (vec_in),
  .cmp_mode(cmp_mode),
  .inv     (inv),
  .flip    (flip),
  .found   (found),
  .pos     (pos)
);

// File: tb/sim_cldd_top.sv
module sim_cldd_top;
  localparam int CLK_PERIOD = 10;
  localparam int H  = 3;
  localparam int W  = 1 << H;
  localparam int HW = W / 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] vec_in = '1;
  logic         cmp_mode = 1'b0;
  logic         inv = 1'b0;
  logic         flip = 1'b0;
  logic         found;
  logic [H-1:0] pos;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cldd_top #(.H(H)) u0 (
    .clk(clk), .rst(rst), .vec_in(vec_in), .cmp_mode(cmp_mode),
    .inv(inv), .flip(flip), .found(found), .pos(pos)
  );

  task automatic check(input string tag, input logic ef, input logic [H-1:0] ep,
                       input logic check_pos);
    vectors++;
    if (found !== ef || (check_pos && pos !== ep)) begin
      errors++;
      $display("FAIL %s vec=%h cmp=%0b inv=%0b flip=%0b: found=%0b pos=%0d, expected found=%0b pos=%0d",
               tag, vec_in, cmp_mode, inv, flip, found, pos, ef, ep);
    end
  endtask

  // detector reference: loop scan (R3..R6, R10)
  task automatic ref_det(input logic [W-1:0] v, input logic iv, input logic fl,
                         output logic ef, output logic [H-1:0] ep, output string tag);
    logic [W-1:0] t;
    t  = iv ? ~v : v;
    ef = 1'b0;
    ep = fl ? '1 : '0;
    if (fl) begin
      for (int i = W - 1; i >= 0; i--) if (t[i]) begin ef = 1'b1; ep = H'(i); end
    end else begin
      for (int i = 0; i < W; i++) if (t[i]) begin ef = 1'b1; ep = H'(i); end
    end
    if (!ef) tag = "R10";
    else if (fl) tag = iv ? "R6" : "R5";
    else tag = iv ? "R4" : "R3";
  endtask

  // comparator reference: magnitude comparison of de-interleaved operands (R7..R9)
  task automatic ref_cmp(input logic [W-1:0] v, input logic iv, input logic fl,
                         output logic ef, output logic [H-1:0] ep, output string tag);
    logic [HW-1:0] a, b, d;
    logic [H-2:0]  idx;
    logic          p0;
    for (int i = 0; i < HW; i++) begin a[i] = v[2*i+1]; b[i] = v[2*i]; end
    d   = a ^ b;
    ef  = (a != b);
    idx = '0;
    if (fl) begin
      for (int i = HW - 1; i >= 0; i--) if (d[i]) idx = (H-1)'(i);
      p0  = a[idx] ^ iv;
      tag = "R9";
    end else begin
      for (int i = 0; i < HW; i++) if (d[i]) idx = (H-1)'(i);
      p0  = iv ? (a < b) : (a > b);
      tag = iv ? "R8" : "R7";
    end
    ep = {idx, p0};
  endtask

  task automatic apply(input logic [W-1:0] v, input logic cm, input logic iv,
                       input logic fl);
    logic ef;
    logic [H-1:0] ep;
    string tag;
    @(negedge clk);
    vec_in = v; cmp_mode = cm; inv = iv; flip = fl;
    @(negedge clk);
    if (cm) begin
      ref_cmp(v, iv, fl, ef, ep, tag);
      check(tag, ef, ep, ef);
    end else begin
      ref_det(v, iv, fl, ef, ep, tag);
      check(tag, ef, ep, 1'b1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, found=%0b pos=%0d, expected completion", found, pos);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R1: reset clears outputs even with active data
    repeat (3) @(negedge clk);
    check("R1", 1'b0, '0, 1'b1);
    @(negedge clk);
    rst = 1'b0;

    // R2: one-cycle latency, previous result held until the capture edge
    apply(8'h80, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    vec_in = 8'h01;
    #1;
    check("R2", 1'b1, 3'd7, 1'b1);
    @(negedge clk);
    check("R2", 1'b1, 3'd0, 1'b1);

    // exhaustive sweeps: detector then comparator, every inv/flip pairing
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++)
        for (int v = 0; v < W * W / W * (1 << (W - H)) / (1 << (W - H)) * (1 << W) / W; v++)
          apply(W'(v), m[0], c[0], c[1]);

    // R1 again: reset mid-run
    @(negedge clk);
    rst = 1'b1; vec_in = 8'hff;
    @(negedge clk);
    check("R1", 1'b0, '0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule